// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is an up-counting timer that shapes a pulse train of arbitrary duty cycle from two compare values. Compare value A sets the period and compare value B sets the point inside the period where the first edge falls. Each match toggles an internal output flip-flop and raises a one-cycle interrupt pulse. The output pin always carries the inverse of that flip-flop.

Software writes three registers through a simple write port: a control word, compare A and compare B. The timer starts either at once on a control command or when a chosen edge (rising or falling) appears on a trigger input. It then counts the pulses of an external, already prescaled count enable. In continuous operation the counter returns to zero on each A match and the pulse train repeats. In one-shot operation the timer stops itself on the A match. The flip-flop's starting level is taken from a bit of the control word, so the first pulse may be positive or negative.

Top module: `ppg_timer`

## Requirements
- R1: After reset the flip-flop is 0, so `pulse_out` is 1, `irq` is 0 and the timer is stopped. Count ticks have no effect while the timer is stopped.
- R2: Register addresses are 0 for control, 1 for compare A and 2 for compare B. Control bits are [0] pulse mode (1) or timer mode (0), [2:1] start source (00 stop, 01 command, 10 rising trigger edge, 11 falling trigger edge), [3] one-shot and [4] initial level. A control write in pulse mode with source 01 starts the counter from zero, and only cycles with `cnt_tick` high advance it.
- R3: On the tick that brings the count to B, the flip-flop toggles and `irq` is high for the next cycle.
- R4: On the tick that brings the count to A, the flip-flop toggles and `irq` is high for the next cycle.
- R5: In continuous mode the counter clears to zero on the A match and keeps running, so the output period is A ticks.
- R6: In one-shot mode the timer stops on the A match. After that the output holds its level and ticks raise no interrupt.
- R7: With source 10 or 11 the timer waits, armed, and starts only on the selected edge of `trig_in`. The opposite edge does not start it.
- R8: A control write that selects pulse mode while the timer is not running loads the flip-flop from bit [4]. `pulse_out` always shows the inverse of the flip-flop.
- R9: A control write of source 00 while the timer is running stops it, and `pulse_out` keeps the level it had just before the stop.
- R10: A write to compare B is ignored while the control register holds timer mode.
- R11: While the timer is running, control writes do not change the flip-flop, whatever bit [4] holds.
- R12: Each match compares against the compare register's current value. A compare value below the present count is missed until the counter wraps past its maximum or clears, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare A, 2 compare B |
| wr_data | input | CNT_W | Write data |
| cnt_tick | input | 1 | Prescaled count enable, one cycle per count |
| trig_in | input | 1 | External start trigger, synchronous to clk |
| pulse_out | output | 1 | Pulse output, the inverse of the output flip-flop |
| irq | output | 1 | One-cycle interrupt pulse after each compare match |

## Verification
The hardest situation to reach is a compare value moved below the running count, so that the match is skipped until the counter wraps through its maximum. The bench uses a 6-bit counter so that a full wrap takes only 64 ticks. Mid-period, it rewrites compare B below the count in one run and compare A below the count in another, then keeps ticking through the skip and the wrap. The output and the interrupt are compared on every cycle against an arithmetic model of the count.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;

  localparam int unsigned CTL_BIT_MODE = 0;
  localparam int unsigned CTL_BIT_SRC  = 1;
  localparam int unsigned CTL_BIT_OS   = 3;
  localparam int unsigned CTL_BIT_INIT = 4;
  localparam int unsigned CTL_W        = 5;

  typedef enum logic [1:0] {
    SRC_STOP = 2'b00,
    SRC_CMD  = 2'b01,
    SRC_RISE = 2'b10,
    SRC_FALL = 2'b11
  } start_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } run_state_e;

  typedef struct packed {
    logic       pulse_mode;
    start_src_e src;
    logic       one_shot;
    logic       init_lvl;
  } ctl_word_t;

  function automatic ctl_word_t decode_ctl(input logic [CTL_W-1:0] bits);
    ctl_word_t c;
    c.pulse_mode = bits[CTL_BIT_MODE];
    c.src        = start_src_e'(bits[CTL_BIT_SRC +: 2]);
    c.one_shot   = bits[CTL_BIT_OS];
    c.init_lvl   = bits[CTL_BIT_INIT];
    return c;
  endfunction

  // Next state of the run controller for a control write.
  function automatic run_state_e state_on_write(input run_state_e cur,
                                                input ctl_word_t  nw);
    if (nw.src == SRC_STOP || !nw.pulse_mode) return ST_IDLE;
    if (cur == ST_RUN)                        return ST_RUN;
    if (nw.src == SRC_CMD)                    return ST_RUN;
    return ST_ARMED;
  endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              os_stop,
  output logic              ctl_wr,
  output ctl_word_t         ctl_new,
  output start_src_e        src_q,
  output logic              one_shot_q,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b
);

  logic mode_q;
  logic wr_a;
  logic wr_b_req;
  logic wr_b_ok;

  assign ctl_wr   = wr_en && (wr_addr == ADDR_CTL);
  assign wr_a     = wr_en && (wr_addr == ADDR_CMPA);
  assign wr_b_req = wr_en && (wr_addr == ADDR_CMPB);
  assign wr_b_ok  = wr_b_req && mode_q;
  assign ctl_new  = decode_ctl(wr_data[CTL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      src_q      <= SRC_STOP;
      one_shot_q <= 1'b0;
    end else if (ctl_wr) begin
      mode_q     <= ctl_new.pulse_mode;
      src_q      <= ctl_new.src;
      one_shot_q <= ctl_new.one_shot;
    end else if (os_stop) begin
      src_q      <= SRC_STOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a <= '0;
    end else if (wr_a) begin
      cmp_a <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_b <= '0;
    end else if (wr_b_ok) begin
      cmp_b <= wr_data;
    end
  end

endmodule

// File: rtl/ppg_start_ctl.sv
module ppg_start_ctl
  import ppg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  ctl_word_t  ctl_new,
  input  start_src_e src_q,
  input  logic       one_shot_q,
  input  logic       trig_in,
  input  logic       hit_a,
  output logic       running,
  output logic       os_stop,
  output logic       ff_load,
  output logic       ff_load_val
);

  run_state_e state_q;
  run_state_e state_d;
  logic       trig_q;
  logic       rise_seen;
  logic       fall_seen;
  logic       edge_ok;

  assign rise_seen = trig_in && !trig_q;
  assign fall_seen = !trig_in && trig_q;
  assign edge_ok   = (src_q == SRC_RISE && rise_seen) ||
                     (src_q == SRC_FALL && fall_seen);

  assign running     = (state_q == ST_RUN);
  assign os_stop     = running && hit_a && one_shot_q && !ctl_wr;
  assign ff_load     = ctl_wr && ctl_new.pulse_mode && !running;
  assign ff_load_val = ctl_new.init_lvl;

  always_comb begin
    state_d = state_q;
    if (ctl_wr) begin
      state_d = state_on_write(state_q, ctl_new);
    end else begin
      case (state_q)
        ST_ARMED: if (edge_ok) state_d = ST_RUN;
        ST_RUN:   if (os_stop) state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_in;
    end
  end

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] count,
  output logic             hit_a,
  output logic             hit_b
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + ONE;
  endfunction

  function automatic logic lands_on(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] target);
    return step_count(c) == target;
  endfunction

  logic advance;

  assign advance = running && tick;
  assign hit_a   = advance && lands_on(count, cmp_a);
  assign hit_b   = advance && lands_on(count, cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!running) begin
      count <= '0;
    end else if (advance) begin
      count <= hit_a ? '0 : step_count(count);
    end
  end

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff (
  input  logic clk,
  input  logic rst_n,
  input  logic ff_load,
  input  logic ff_load_val,
  input  logic hit_a,
  input  logic hit_b,
  output logic ff_q,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      ff_q <= ff_load ? ff_load_val : (ff_q ^ hit_a ^ hit_b);
      irq  <= hit_a | hit_b;
    end
  end

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cnt_tick,
  input  logic              trig_in,
  output logic              pulse_out,
  output logic              irq
);

  logic             ctl_wr;
  ctl_word_t        ctl_new;
  start_src_e       src_q;
  logic             os_mode;
  logic [CNT_W-1:0] cmp_a;
  logic [CNT_W-1:0] cmp_b;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             os_stop;
  logic             ff_load;
  logic             ff_load_val;
  logic             hit_a;
  logic             hit_b;
  logic             ff_q;

  ppg_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .os_stop(os_stop), .ctl_wr(ctl_wr),
    .ctl_new(ctl_new), .src_q(src_q), .one_shot_q(os_mode),
    .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  ppg_start_ctl start_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_new(ctl_new),
    .src_q(src_q), .one_shot_q(os_mode), .trig_in(trig_in),
    .hit_a(hit_a), .running(running), .os_stop(os_stop),
    .ff_load(ff_load), .ff_load_val(ff_load_val)
  );

  ppg_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .running(running), .tick(cnt_tick),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .count(count),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  ppg_outff ff_i (
    .clk(clk), .rst_n(rst_n), .ff_load(ff_load), .ff_load_val(ff_load_val),
    .hit_a(hit_a), .hit_b(hit_b), .ff_q(ff_q), .irq(irq)
  );

  assign pulse_out = ~ff_q;

endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             tick,
  input logic             hit_a,
  input logic             hit_b,
  input logic             ff_load,
  input logic             ctl_wr,
  input logic             os_mode,
  input logic [CNT_W-1:0] count,
  input logic             pulse_out,
  input logic             irq
);

  AST_RESET_LEVEL: assert property (@(posedge clk)
    !rst_n |=> (pulse_out && !irq)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !irq); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !hit_a && !ctl_wr) |=>
      (count == CNT_W'($past(count) + 1'b1))); // R2

  AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_a ^ hit_b) && !ff_load) |=> (pulse_out != $past(pulse_out))); // R3

  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a || hit_b) |=> irq); // R4

  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !os_mode && !ctl_wr) |=> (running && count == '0)); // R5

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && os_mode && !ctl_wr) |=> !running); // R6

  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b && !ff_load) |=> $stable(pulse_out)); // R9

endmodule

bind ppg_timer ppg_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .running(running), .tick(cnt_tick),
  .hit_a(hit_a), .hit_b(hit_b), .ff_load(ff_load), .ctl_wr(ctl_wr),
  .os_mode(os_mode), .count(count), .pulse_out(pulse_out), .irq(irq)
);

// File: tb/ppg_timer_tb.sv
module ppg_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam int MASK       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         cnt_tick = 1'b0;
  logic         trig_in = 1'b0;
  logic         pulse_out;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side expectations
  bit m_mode, m_os, m_ff, m_irq, m_trig;
  int m_src, m_state, m_cnt, m_a, m_b; // state: 0 idle, 1 armed, 2 running

  always #(CLK_PERIOD/2) clk = ~clk;

  ppg_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_tick(cnt_tick), .trig_in(trig_in),
    .pulse_out(pulse_out), .irq(irq)
  );

  function automatic logic [W-1:0] ctl(input bit mode, input int src,
                                       input bit os, input bit init);
    return W'({init, os, src[1:0], mode});
  endfunction

  task automatic check(input string rq);
    checks++;
    if (pulse_out !== ~m_ff || irq !== m_irq) begin
      failures++;
      $display("FAIL %s: pulse_out=%0b irq=%0b expected pulse_out=%0b irq=%0b",
               rq, pulse_out, irq, ~m_ff, m_irq);
    end
  endtask

  task automatic wr(input int ad, input int d, input string rq);
    bit mode, os, init;
    int src;
    wr_addr = ad[1:0]; wr_data = d[W-1:0]; wr_en = 1'b1;
    m_irq = 1'b0;
    if (ad == 0) begin
      mode = d[0]; src = (d >> 1) & 3; os = d[3]; init = d[4];
      if (mode && m_state != 2) m_ff = init;
      if (src == 0 || !mode) m_state = 0;
      else if (m_state != 2) m_state = (src == 1) ? 2 : 1;
      if (m_state != 2) m_cnt = 0;
      m_mode = mode; m_src = src; m_os = os;
    end else if (ad == 1) begin
      m_a = d & MASK;
    end else if (ad == 2) begin
      if (m_mode) m_b = d & MASK;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(rq);
  endtask

  task automatic step(input bit t, input string rq);
    int nxt;
    bit ha, hb;
    cnt_tick = t;
    m_irq = 1'b0;
    if (t && m_state == 2) begin
      nxt = (m_cnt + 1) & MASK;
      ha = (nxt == m_a);
      hb = (nxt == m_b);
      m_ff = m_ff ^ ha ^ hb;
      m_irq = ha | hb;
      if (ha) begin
        m_cnt = 0;
        if (m_os) begin m_state = 0; m_src = 0; end
      end else begin
        m_cnt = nxt;
      end
    end
    @(negedge clk);
    cnt_tick = 1'b0;
    check(rq);
  endtask

  task automatic trig(input bit v, input string rq);
    m_irq = 1'b0;
    if (m_state == 1 && ((m_src == 2 && v && !m_trig) ||
                         (m_src == 3 && !v && m_trig))) m_state = 2;
    m_trig = v;
    trig_in = v;
    @(negedge clk);
    check(rq);
  endtask

  task automatic ticks(input int n, input string rq);
    for (int i = 0; i < n; i++) step(1'b1, rq);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    m_mode = 0; m_os = 0; m_ff = 0; m_irq = 0; m_trig = 0;
    m_src = 0; m_state = 0; m_cnt = 0; m_a = 0; m_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level");
    ticks(4, "R1 ticks while stopped");

    // R8: load of the flip-flop from the initial-level bit
    wr(0, ctl(1, 0, 0, 1), "R8 load level 1");
    wr(0, ctl(0, 0, 0, 0), "R8 timer mode keeps level");
    wr(0, ctl(1, 0, 0, 0), "R8 load level 0");

    // R2 R3 R4 R5: continuous sweep over compare pairs
    for (int a = 2; a <= 12; a++) begin
      for (int b = 1; b < a; b++) begin
        bit init = bit'((a + b) & 1);
        wr(0, ctl(1, 0, 0, init), "R8 setup");
        wr(1, a, "R4 set A");
        wr(2, b, "R3 set B");
        wr(0, ctl(1, 1, 0, init), "R2 command start");
        for (int n = 0; n < 2 * a + 1; n++) begin
          step(1'b1, "R3/R4/R5 continuous");
          if (n % 4 == 3) step(1'b0, "R2 no tick");
        end
        wr(0, ctl(1, 0, 0, init), "R9 software stop");
        ticks(2, "R9 held after stop");
      end
    end

    // R6: one-shot runs
    for (int a = 3; a <= 9; a++) begin
      bit init = bit'(a & 1);
      wr(0, ctl(1, 0, 1, init), "R6 setup");
      wr(1, a, "R6 set A");
      wr(2, a - 2, "R6 set B");
      wr(0, ctl(1, 1, 1, init), "R6 start");
      ticks(a + 4, "R6 one-shot");
    end

    // R7: rising-edge start
    wr(0, ctl(1, 0, 0, 1), "R7 setup");
    wr(1, 12, "R7 set A");
    wr(2, 5, "R7 set B");
    trig(1'b0, "R7 trigger low");
    wr(0, ctl(1, 2, 0, 1), "R7 arm rising");
    ticks(3, "R7 armed, not counting");
    trig(1'b1, "R7 rising edge");
    ticks(14, "R7 after rising start");
    wr(0, ctl(1, 0, 0, 1), "R9 stop");
    // R7: falling-edge start, rising edge must not start it
    trig(1'b0, "R7 trigger low");
    wr(0, ctl(1, 3, 0, 0), "R7 arm falling");
    trig(1'b1, "R7 rising edge ignored");
    ticks(3, "R7 still armed");
    trig(1'b0, "R7 falling edge");
    ticks(14, "R7 after falling start");
    wr(0, ctl(1, 0, 0, 0), "R9 stop");

    // R10: compare B write in timer mode is dropped
    wr(2, 3, "R10 set B in pulse mode");
    wr(1, 8, "R10 set A");
    wr(0, ctl(0, 0, 0, 0), "R10 timer mode");
    wr(2, 6, "R10 write B ignored");
    wr(0, ctl(1, 1, 0, 0), "R10 start");
    ticks(10, "R10 B stays 3");
    wr(0, ctl(1, 0, 0, 0), "R9 stop");

    // R11: level bit ignored while running
    wr(1, 20, "R11 set A");
    wr(2, 10, "R11 set B");
    wr(0, ctl(1, 1, 0, 0), "R11 start");
    ticks(3, "R11 running");
    wr(0, ctl(1, 1, 0, 1), "R11 level write ignored");
    ticks(25, "R11 pattern unchanged");
    wr(0, ctl(1, 0, 0, 0), "R9 stop");

    // R12: compare below count is skipped
    wr(1, 40, "R12 set A");
    wr(2, 30, "R12 set B");
    wr(0, ctl(1, 1, 0, 1), "R12 start");
    ticks(10, "R12 run");
    wr(2, 5, "R12 B below count");
    ticks(50, "R12 B skipped");
    wr(0, ctl(1, 0, 0, 1), "R9 stop");
    wr(1, 30, "R12 set A");
    wr(2, 20, "R12 set B");
    wr(0, ctl(1, 1, 0, 0), "R12 start");
    ticks(25, "R12 run");
    wr(1, 10, "R12 A below count");
    ticks(60, "R12 wrap then A match");
    wr(0, ctl(1, 0, 0, 0), "R9 stop");
    ticks(3, "R9 held");

    finish_run();
  end

endmodule